// File: doc/BRIEF.md
# Conditional Paired Store Unit

This unit carries out one store-exclusive of a register pair. A request brings two register values, a base register value with its index, the stack pointer, a size select and a byte-order flag. The unit keeps a local reservation, which is a granule address with a size that a preceding load-exclusive arms through a set port. Each request is checked against that reservation. When the reservation covers the target, the two elements are merged into one combined word and sent to memory as a single write request with full byte enables. After that write is accepted, the unit returns a zero-extended status of 0. When the reservation does not cover the target, nothing is written and the status is 1.

Faults stop the update. A misaligned target that the reservation covers raises an alignment fault. A base index of 31 selects the stack pointer as the address, and that pointer must be 16-byte aligned. A synchronous abort reported with the request suppresses both the memory write and the status write. Every attempt clears the reservation, whatever its outcome.

Top module: `sxp_unit`

## Requirements
- R1: On a reservation match with an aligned target, exactly one memory write is issued at the target address, with byte enables 0x00FF for 32-bit elements and 0xFFFF for 64-bit elements. The status written back is 0.
- R2: With no valid reservation, or a reservation at another granule, no memory write is issued and status 1 is written back.
- R3: With 32-bit elements (wide_i=0), the write data bits [63:0] are {elem1[31:0], elem0[31:0]} when little-endian (big_endian_i=0) and {elem0[31:0], elem1[31:0]} when big-endian. Bits [127:64] are zero.
- R4: With 64-bit elements (wide_i=1), the write data is {elem1, elem0} when little-endian and {elem0, elem1} when big-endian.
- R5: A target that is not 8-byte aligned (32-bit elements) or not 16-byte aligned (64-bit elements) while the reservation matches gives rsp_align_fault_o=1, no memory write and no status write.
- R6: A misaligned target without a reservation match gives no fault and status 1, with no memory write.
- R7: A base index of 31 takes the address from sp_i. If sp_i[3:0] is nonzero, rsp_sp_fault_o=1, no write and no status write, whatever the reservation holds. This fault outranks every other outcome.
- R8: A request with abort_i=1 (and no stack-pointer fault) produces a response with no memory write, no status write and no fault flag.
- R9: The reservation is cleared by every accepted attempt, so a second attempt to the same target without a new set returns status 1.
- R10: mem_valid_o stays high with stable address and data until mem_ready_i. The response comes in the cycle after the write handshake, and rsp_status_o bits [31:1] are zero.
- R11: A reservation matches only when its size equals the request's size select. A reservation set with rsv_wide_i differing from wide_i yields status 1.
- R12: req_ready_o is high only while no request is in flight. A response is a single-cycle pulse on rsp_valid_o, followed by req_ready_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsv_set_i | input | 1 | Arm the reservation |
| rsv_addr_i | input | 64 | Reservation address |
| rsv_wide_i | input | 1 | Reservation size: 1 = 16-byte granule, 0 = 8-byte |
| req_valid_i | input | 1 | Store request valid |
| req_ready_o | output | 1 | Unit idle, request accepted |
| wide_i | input | 1 | Element size: 1 = 64-bit, 0 = 32-bit |
| big_endian_i | input | 1 | Byte-order flag |
| base_idx_i | input | 5 | Base register index |
| base_val_i | input | 64 | Base register value |
| sp_i | input | 64 | Stack pointer value |
| elem0_i | input | 64 | First register value |
| elem1_i | input | 64 | Second register value |
| abort_i | input | 1 | Synchronous abort for this request |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory write accepted |
| mem_addr_o | output | 64 | Write address |
| mem_data_o | output | 128 | Combined write data |
| mem_be_o | output | 16 | Byte enables |
| rsp_valid_o | output | 1 | Completion pulse |
| rsp_status_we_o | output | 1 | Status write-back enable |
| rsp_status_o | output | 32 | Zero-extended status |
| rsp_align_fault_o | output | 1 | Alignment fault |
| rsp_sp_fault_o | output | 1 | Stack-pointer alignment fault |

## Verification
The assertions assume that request fields are held steady only in the acceptance cycle and that mem_ready_i may stall for any number of cycles. They also assume that a reservation set never coincides with an accepted request. The stimulus drives each request for exactly one cycle while the unit is idle. It arms the reservation only between attempts, and it randomizes the memory stall per cycle. Random addresses are drawn from a small window around the reserved granule, so matches, near misses and misalignments all occur often.

// File: rtl/sxp_pkg.sv
package sxp_pkg;
  typedef enum logic [2:0] {
    OUT_PASS,
    OUT_FAIL,
    OUT_ALIGN,
    OUT_SPALIGN,
    OUT_ABORT
  } sxp_outcome_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_RESP
  } sxp_state_e;
endpackage

// File: rtl/sxp_resv.sv
module sxp_resv #(
  parameter int unsigned AW      = 64,
  parameter int unsigned NAR_LSB = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic          set_wide_i,
  input  logic          clr_i,
  output logic          valid_o,
  output logic          wide_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned WID_LSB = NAR_LSB + 1;
  localparam logic [AW-1:0] NAR_MASK = AW'((1 << NAR_LSB) - 1);
  localparam logic [AW-1:0] WID_MASK = AW'((1 << WID_LSB) - 1);

  logic          valid_q, wide_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
    end else if (clr_i) begin
      // an attempt always consumes the reservation
      valid_q <= 1'b0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      wide_q  <= set_wide_i;
      addr_q  <= set_addr_i & ~(set_wide_i ? WID_MASK : NAR_MASK);
    end
  end

  assign valid_o = valid_q;
  assign wide_o  = wide_q;
  assign addr_o  = addr_q;

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_q);
endmodule

// File: rtl/sxp_check.sv
module sxp_check
  import sxp_pkg::*;
#(
  parameter int unsigned AW        = 64,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned NAR_LSB   = 3,
  parameter int unsigned SP_LSB    = 4
) (
  input  logic [IDX_W-1:0] base_idx_i,
  input  logic [AW-1:0]    base_val_i,
  input  logic [AW-1:0]    sp_i,
  input  logic             wide_i,
  input  logic             abort_i,
  input  logic             rsv_valid_i,
  input  logic             rsv_wide_i,
  input  logic [AW-1:0]    rsv_addr_i,
  output logic [AW-1:0]    addr_o,
  output sxp_outcome_e     outcome_o
);
  localparam int unsigned WID_LSB = NAR_LSB + 1;
  localparam logic [AW-1:0] NAR_MASK = AW'((1 << NAR_LSB) - 1);
  localparam logic [AW-1:0] WID_MASK = AW'((1 << WID_LSB) - 1);
  localparam logic [AW-1:0] SP_MASK  = AW'((1 << SP_LSB) - 1);
  localparam logic [IDX_W-1:0] SP_IDX = '1;

  logic          use_sp, sp_bad, misalign, match;
  logic [AW-1:0] mask;

  always_comb begin
    use_sp   = (base_idx_i == SP_IDX);
    addr_o   = use_sp ? sp_i : base_val_i;
    sp_bad   = use_sp && ((sp_i & SP_MASK) != '0);
    mask     = wide_i ? WID_MASK : NAR_MASK;
    misalign = (addr_o & mask) != '0;
    match    = rsv_valid_i && (rsv_wide_i == wide_i) &&
               ((rsv_addr_i & ~mask) == (addr_o & ~mask));
    if (sp_bad)               outcome_o = OUT_SPALIGN;
    else if (abort_i)         outcome_o = OUT_ABORT;
    else if (match && misalign) outcome_o = OUT_ALIGN;
    else if (match)           outcome_o = OUT_PASS;
    else                      outcome_o = OUT_FAIL;
  end
endmodule

// File: rtl/sxp_pack.sv
module sxp_pack #(
  parameter int unsigned XLEN = 64
) (
  input  logic                  wide_i,
  input  logic                  big_endian_i,
  input  logic [XLEN-1:0]       elem0_i,
  input  logic [XLEN-1:0]       elem1_i,
  output logic [2*XLEN-1:0]     data_o,
  output logic [2*XLEN/8-1:0]   be_o
);
  localparam int unsigned HALF   = XLEN / 2;
  localparam int unsigned NBYTES = 2 * XLEN / 8;
  localparam logic [XLEN-1:0] LO_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [XLEN-1:0] hi, lo, narrow_word;

  always_comb begin
    hi          = big_endian_i ? elem0_i : elem1_i;
    lo          = big_endian_i ? elem1_i : elem0_i;
    narrow_word = (hi << HALF) | (lo & LO_MASK);
    data_o      = wide_i ? {hi, lo} : {{XLEN{1'b0}}, narrow_word};
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_be
    if (b < NBYTES / 2) begin : g_lo
      assign be_o[b] = 1'b1;
    end else begin : g_hi
      assign be_o[b] = wide_i;
    end
  end
endmodule

// File: rtl/sxp_unit.sv
module sxp_unit
  import sxp_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned STATUS_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rsv_set_i,
  input  logic [XLEN-1:0]      rsv_addr_i,
  input  logic                 rsv_wide_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 wide_i,
  input  logic                 big_endian_i,
  input  logic [IDX_W-1:0]     base_idx_i,
  input  logic [XLEN-1:0]      base_val_i,
  input  logic [XLEN-1:0]      sp_i,
  input  logic [XLEN-1:0]      elem0_i,
  input  logic [XLEN-1:0]      elem1_i,
  input  logic                 abort_i,
  output logic                 mem_valid_o,
  input  logic                 mem_ready_i,
  output logic [XLEN-1:0]      mem_addr_o,
  output logic [2*XLEN-1:0]    mem_data_o,
  output logic [2*XLEN/8-1:0]  mem_be_o,
  output logic                 rsp_valid_o,
  output logic                 rsp_status_we_o,
  output logic [STATUS_W-1:0]  rsp_status_o,
  output logic                 rsp_align_fault_o,
  output logic                 rsp_sp_fault_o
);
  localparam int unsigned DW      = 2 * XLEN;
  localparam int unsigned BW      = DW / 8;
  localparam int unsigned NAR_LSB = $clog2(XLEN / 8);
  localparam int unsigned SP_LSB  = NAR_LSB + 1;

  sxp_state_e        state_q;
  logic              accept;
  logic              rsv_valid, rsv_wide;
  logic [XLEN-1:0]   rsv_addr, tgt_addr;
  sxp_outcome_e      outcome;
  logic [DW-1:0]     pk_data;
  logic [BW-1:0]     pk_be;

  logic [XLEN-1:0]   addr_q;
  logic [DW-1:0]     data_q;
  logic [BW-1:0]     be_q;
  logic              st_q, swe_q, alf_q, spf_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  sxp_resv #(.AW(XLEN), .NAR_LSB(NAR_LSB)) u_resv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (rsv_set_i),
    .set_addr_i(rsv_addr_i),
    .set_wide_i(rsv_wide_i),
    .clr_i     (accept),
    .valid_o   (rsv_valid),
    .wide_o    (rsv_wide),
    .addr_o    (rsv_addr)
  );

  sxp_check #(.AW(XLEN), .IDX_W(IDX_W), .NAR_LSB(NAR_LSB), .SP_LSB(SP_LSB)) u_check (
    .base_idx_i (base_idx_i),
    .base_val_i (base_val_i),
    .sp_i       (sp_i),
    .wide_i     (wide_i),
    .abort_i    (abort_i),
    .rsv_valid_i(rsv_valid),
    .rsv_wide_i (rsv_wide),
    .rsv_addr_i (rsv_addr),
    .addr_o     (tgt_addr),
    .outcome_o  (outcome)
  );

  sxp_pack #(.XLEN(XLEN)) u_pack (
    .wide_i      (wide_i),
    .big_endian_i(big_endian_i),
    .elem0_i     (elem0_i),
    .elem1_i     (elem1_i),
    .data_o      (pk_data),
    .be_o        (pk_be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      be_q    <= '0;
      st_q    <= 1'b1;
      swe_q   <= 1'b0;
      alf_q   <= 1'b0;
      spf_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q <= tgt_addr;
          data_q <= pk_data;
          be_q   <= pk_be;
          st_q   <= 1'b1;
          swe_q  <= (outcome == OUT_FAIL);
          alf_q  <= (outcome == OUT_ALIGN);
          spf_q  <= (outcome == OUT_SPALIGN);
          state_q <= (outcome == OUT_PASS) ? ST_WRITE : ST_RESP;
        end
        ST_WRITE: if (mem_ready_i) begin
          st_q    <= 1'b0;
          swe_q   <= 1'b1;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid_o       = (state_q == ST_WRITE);
  assign mem_addr_o        = addr_q;
  assign mem_data_o        = data_q;
  assign mem_be_o          = be_q;
  assign rsp_valid_o       = (state_q == ST_RESP);
  assign rsp_status_we_o   = rsp_valid_o && swe_q;
  assign rsp_status_o      = {{(STATUS_W-1){1'b0}}, st_q};
  assign rsp_align_fault_o = rsp_valid_o && alf_q;
  assign rsp_sp_fault_o    = rsp_valid_o && spf_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));
  p_ok_after_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_status_we_o && (rsp_status_o == '0) |-> $past(mem_valid_o && mem_ready_i));
  p_fault_no_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_align_fault_o || rsp_sp_fault_o) |-> !rsp_status_we_o);
  p_one_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_align_fault_o, rsp_sp_fault_o, rsp_status_we_o}) <= 1);
  p_ready_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_valid_o && !rsp_valid_o);
  p_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
  p_write_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_be_o[BW-1] ? (mem_addr_o[SP_LSB-1:0] == '0)
                                    : (mem_addr_o[NAR_LSB-1:0] == '0)));
endmodule

// File: tb/sxp_unit_tb_top.sv
module sxp_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic rsv_set = 0, rsv_wide = 0, req_valid = 0, wide = 0, be_mode = 0, abort = 0, mem_ready = 0;
  logic [63:0] rsv_addr = '0, base_val = '0, sp = '0, e0 = '0, e1 = '0;
  logic [4:0] base_idx = '0;
  logic req_ready, mem_valid, rsp_valid, rsp_swe, rsp_alf, rsp_spf;
  logic [63:0] mem_addr;
  logic [127:0] mem_data;
  logic [15:0] mem_be;
  logic [31:0] rsp_status;

  sxp_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rsv_set_i(rsv_set), .rsv_addr_i(rsv_addr), .rsv_wide_i(rsv_wide),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .wide_i(wide), .big_endian_i(be_mode), .base_idx_i(base_idx),
    .base_val_i(base_val), .sp_i(sp), .elem0_i(e0), .elem1_i(e1), .abort_i(abort),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .mem_be_o(mem_be),
    .rsp_valid_o(rsp_valid), .rsp_status_we_o(rsp_swe), .rsp_status_o(rsp_status),
    .rsp_align_fault_o(rsp_alf), .rsp_sp_fault_o(rsp_spf)
  );

  int tests = 0, fails = 0;
  logic m_rv = 0, m_rw = 0;
  logic [63:0] m_ra = '0;

  int n_wr; logic [63:0] w_addr; logic [127:0] w_data; logic [15:0] w_be;
  logic got_rsp, r_swe, r_alf, r_spf, stall_ok, busy_ok; logic [31:0] r_st;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_data(logic w, logic b, logic [63:0] a0, logic [63:0] a1);
    if (w) return b ? {a0, a1} : {a1, a0};
    return b ? {64'd0, a0[31:0], a1[31:0]} : {64'd0, a1[31:0], a0[31:0]};
  endfunction

  task automatic set_rsv(input logic [63:0] a, input logic w);
    @(negedge clk);
    rsv_set = 1; rsv_addr = a; rsv_wide = w;
    @(negedge clk);
    rsv_set = 0;
    m_rv = 1; m_rw = w; m_ra = a & ~(w ? 64'hF : 64'h7);
  endtask

  task automatic run_op(input logic w, input logic b, input logic [4:0] idx,
                        input logic [63:0] bv, input logic [63:0] spv,
                        input logic [63:0] a0, input logic [63:0] a1, input logic ab);
    logic stalled = 0; logic [63:0] pa; logic [127:0] pd;
    n_wr = 0; got_rsp = 0; stall_ok = 1; busy_ok = 1; pa = '0; pd = '0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R12", "ready before request", {127'd0, req_ready}, 1);
    wide = w; be_mode = b; base_idx = idx; base_val = bv; sp = spv; e0 = a0; e1 = a1; abort = ab;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0; abort = 0;
    for (int i = 0; i < 60 && !got_rsp; i++) begin
      if (rsp_valid) begin
        got_rsp = 1; r_swe = rsp_swe; r_st = rsp_status; r_alf = rsp_alf; r_spf = rsp_spf;
      end else begin
        if (req_ready) busy_ok = 0;
        if (mem_valid) begin
          if (stalled && (mem_addr !== pa || mem_data !== pd)) stall_ok = 0;
          pa = mem_addr; pd = mem_data;
          mem_ready = ($urandom % 3) == 0;
          stalled = !mem_ready;
          if (mem_ready) begin n_wr++; w_addr = mem_addr; w_data = mem_data; w_be = mem_be; end
        end else mem_ready = 0;
        @(negedge clk);
      end
    end
    mem_ready = 0;
  endtask

  task automatic op_check(input logic w, input logic b, input logic [4:0] idx,
                          input logic [63:0] bv, input logic [63:0] spv,
                          input logic [63:0] a0, input logic [63:0] a1, input logic ab);
    logic [63:0] a, mask; logic spbad, match, mis, pass;
    a = (idx == 5'd31) ? spv : bv;
    mask = w ? 64'hF : 64'h7;
    spbad = (idx == 5'd31) && (spv[3:0] != 0);
    mis = (a & mask) != 0;
    match = m_rv && (m_rw == w) && ((m_ra & ~mask) == (a & ~mask));
    run_op(w, b, idx, bv, spv, a0, a1, ab);
    m_rv = 0;
    pass = !spbad && !ab && match && !mis;
    chk(got_rsp, "R12", "response seen", {127'd0, got_rsp}, 1);
    chk(busy_ok, "R12", "ready low while busy", {127'd0, busy_ok}, 1);
    chk(stall_ok, "R10", "stable under stall", {127'd0, stall_ok}, 1);
    chk(r_spf == spbad, "R7", "sp fault", {127'd0, r_spf}, {127'd0, spbad});
    chk(r_alf == (!spbad && !ab && match && mis), "R5", "align fault", {127'd0, r_alf},
        {127'd0, !spbad && !ab && match && mis});
    if (spbad || ab || (match && mis)) begin
      chk(n_wr == 0 && !r_swe, ab ? "R8" : "R5", "no write, no status",
          {96'd0, n_wr[30:0], r_swe}, 0);
    end else if (pass) begin
      chk(n_wr == 1, "R1", "write count", n_wr, 1);
      chk(w_addr == a, "R1", "write addr", w_addr, a);
      chk(w_be == (w ? 16'hFFFF : 16'h00FF), "R1", "byte enables", w_be, w ? 16'hFFFF : 16'h00FF);
      chk(w_data == exp_data(w, b, a0, a1), w ? "R4" : "R3", "packed data", w_data,
          exp_data(w, b, a0, a1));
      chk(r_swe && r_st == 32'd0, "R10", "status zero", {95'd0, r_swe, r_st}, {95'd0, 1'b1, 32'd0});
    end else begin
      chk(n_wr == 0 && r_swe && r_st == 32'd1, mis ? "R6" : "R2", "fail status",
          {63'd0, n_wr[30:0], r_swe, r_st}, {95'd0, 1'b1, 32'd1});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(req_ready === 1 && mem_valid === 0 && rsp_valid === 0, "R12", "reset state",
        {125'd0, req_ready, mem_valid, rsp_valid}, 3'b100);
    rst_n = 1;
    // R1 R3: narrow pass, both byte orders
    set_rsv(64'h1000, 0);
    op_check(0, 0, 5'd3, 64'h1000, 64'h0, 64'h1111_2222_aaaa_bbbb, 64'h3333_4444_cccc_dddd, 0);
    set_rsv(64'h1008, 0);
    op_check(0, 1, 5'd3, 64'h1008, 64'h0, 64'h1111_2222_aaaa_bbbb, 64'h3333_4444_cccc_dddd, 0);
    // R4: wide pass, both byte orders
    set_rsv(64'h2000, 1);
    op_check(1, 0, 5'd7, 64'h2000, 64'h0, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 0);
    set_rsv(64'h2010, 1);
    op_check(1, 1, 5'd7, 64'h2010, 64'h0, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 0);
    // R2: no reservation; R9: second attempt after a consumed reservation
    op_check(0, 0, 5'd1, 64'h3000, 64'h0, 64'h5, 64'h6, 0);
    set_rsv(64'h3000, 0);
    op_check(0, 0, 5'd1, 64'h3000, 64'h0, 64'h5, 64'h6, 0);
    op_check(0, 0, 5'd1, 64'h3000, 64'h0, 64'h5, 64'h6, 0);
    // R5: misaligned match; R6: misaligned without match
    set_rsv(64'h4000, 1);
    op_check(1, 0, 5'd2, 64'h4008, 64'h0, 64'h7, 64'h8, 0);
    op_check(1, 0, 5'd2, 64'h4008, 64'h0, 64'h7, 64'h8, 0);
    // R7: stack pointer path, aligned and misaligned
    set_rsv(64'h5000, 1);
    op_check(1, 0, 5'd31, 64'h9999, 64'h5000, 64'h9, 64'hA, 0);
    set_rsv(64'h5008, 0);
    op_check(0, 0, 5'd31, 64'h5008, 64'h5008, 64'h9, 64'hA, 0);
    // R8: abort with matching reservation
    set_rsv(64'h6000, 0);
    op_check(0, 1, 5'd4, 64'h6000, 64'h0, 64'hB, 64'hC, 1);
    // R11: size mismatch
    set_rsv(64'h7000, 0);
    op_check(1, 0, 5'd4, 64'h7000, 64'h0, 64'hD, 64'hE, 0);
    for (int k = 0; k < 300; k++) begin
      logic [63:0] g, t, s;
      logic [4:0] ix;
      g = {48'd0, 16'($urandom) & 16'h00F0} + 64'h8000;
      if ($urandom % 4 != 0) set_rsv(g + 64'($urandom % 4), 1'($urandom));
      t = g + 64'($urandom % 24);
      s = (($urandom % 3) == 0) ? t : (g & ~64'hF);
      ix = (($urandom % 4) == 0) ? 5'd31 : 5'($urandom % 31);
      op_check(1'($urandom), 1'($urandom), ix, t, s,
               {$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 10) == 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule